// File: doc/BRIEF.md
# Port Pin Alternate-Function Multiplexer

This block owns the pads of an eight-pin general-purpose port and decides, pin by pin, who drives each pad. Each pin has three possible owners. A pulse-width-modulation channel output comes first. A signal from a routed serial-peripheral-interface (SPI) engine comes second. Plain GPIO, driven from a software data register, comes last. The PWM generator and the SPI engines sit outside the block. They only supply their enables, their master/slave mode and their output levels.

A simple register bus exposes two registers. The data register sits at byte address 0x0258, and the direction register sits at 0x025A. Both can be read and written at any time. A read of the data register mixes two sources: for output pins it returns the stored bit, and for input pins it returns the pad level after a two-flop synchronizer. Each pin's ownership is an enumerated state with three values: GPIO, SPI and PWM. The state moves combinationally. It goes to PWM whenever the pin's channel enable rises. It goes to SPI when the PWM enable is low and the pin's SPI is enabled. It falls back to GPIO when both enables are low.

Top module: `pin_owner_mux`

## Requirements
- R1: After reset the data and direction registers read 0x00, and with no alternate function enabled every pin_oe bit is 0.
- R2: A bus write to address 0x0258 stores bus_wdata in the data register. A read of 0x0258 returns the stored bit for every pin whose direction bit is 1.
- R3: For a pin whose direction bit is 0, a read of 0x0258 returns pin_in after two rising clock edges. After one edge it still returns the old level.
- R4: When pwm_en[i] is 1, pin_out[i] equals pwm_val[i] and pin_oe[i] is 1, whatever the SPI and GPIO settings are.
- R5: When pwm_en[i] is 0 and the pin's SPI is enabled, pin_out[i] carries that SPI signal. As master the SPI drives SCK, SS and MOSI (oe=1) and releases MISO (oe=0). As slave only MISO is driven.
- R6: Pins 7,6,5,4 carry SCK, SS, MOSI and MISO of SPI index 1. Pins 3,2,1,0 carry SS, SCK, MOSI and MISO of SPI index 0. The SPI vectors use index 0 for pins 3..0 and index 1 for pins 7..4.
- R7: With both alternate functions off, pin_out[i] equals the data bit and pin_oe[i] equals the direction bit.
- R8: A data write while an alternate function owns the pin is stored anyway. The value appears on pin_out once GPIO regains the pin.
- R9: The direction register reads back at 0x025A. Writes to any other address change neither register, and reads of other addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pwm_en | input | 8 | Per-pin PWM channel enable |
| pwm_val | input | 8 | Per-pin PWM channel level |
| spi_en | input | 2 | Routed SPI enable per SPI |
| spi_master | input | 2 | 1 = SPI in master mode |
| spi_sck | input | 2 | SPI clock level per SPI |
| spi_ss | input | 2 | SPI select level per SPI |
| spi_mosi | input | 2 | SPI MOSI level per SPI |
| spi_miso | input | 2 | SPI MISO level per SPI |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |

## Verification
The hardest case to reach from the ports is the role mapping of R6. When every SPI signal is at the same level, a swapped SCK/SS pair looks correct. The stimulus therefore raises one SPI signal at a time in one SPI, and checks that exactly one pin moves. Stored-but-hidden data (R8) is also easy to miss. It is reached by writing the data register under a PWM override and then dropping the enable.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    typedef enum logic [1:0] {
        OWNER_GPIO,
        OWNER_SPI,
        OWNER_PWM
    } owner_e;

    typedef enum logic [1:0] {
        ROLE_MISO,
        ROLE_MOSI,
        ROLE_SCK,
        ROLE_SS
    } spi_role_e;

    // Position within a group of four; even groups put SS above SCK, odd groups the reverse.
    function automatic spi_role_e role_of(input int pin_idx);
        int pos;
        bit odd_group;
        pos       = pin_idx % 4;
        odd_group = ((pin_idx / 4) % 2) == 1;
        unique case (pos)
            3:       role_of = odd_group ? ROLE_SCK : ROLE_SS;
            2:       role_of = odd_group ? ROLE_SS  : ROLE_SCK;
            1:       role_of = ROLE_MOSI;
            default: role_of = ROLE_MISO;
        endcase
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/port_regs.sv
module port_regs #(
    parameter int          ADDR_W    = 16,
    parameter int          PORT_W    = 8,
    parameter logic [15:0] DATA_ADDR = 16'h0258,
    parameter logic [15:0] DIR_ADDR  = 16'h025A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic [PORT_W-1:0] pin_level,
    output logic [PORT_W-1:0] bus_rdata,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] dir_q
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_ADDR);

    logic hit_data;
    logic hit_dir;

    assign hit_data = bus_sel && (bus_addr == DATA_A);
    assign hit_dir  = bus_sel && (bus_addr == DIR_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            if (hit_data && bus_wr) data_q <= bus_wdata;
            if (hit_dir  && bus_wr) dir_q  <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            if (hit_data)     bus_rdata = (data_q & dir_q) | (pin_level & ~dir_q);
            else if (hit_dir) bus_rdata = dir_q;
        end
    end

    assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_data && bus_wr) |=> (data_q == $past(bus_wdata)));

    assert_output_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_data && !bus_wr) |-> ((bus_rdata & dir_q) == (data_q & dir_q)));

    assert_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !hit_data && !hit_dir) |=> ($stable(data_q) && $stable(dir_q)));

endmodule

// File: rtl/pin_owner_cell.sv
module pin_owner_cell
    import pinmux_pkg::*;
#(
    parameter spi_role_e ROLE = ROLE_MISO
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_en,
    input  logic pwm_val,
    input  logic spi_en,
    input  logic spi_master,
    input  logic spi_sck,
    input  logic spi_ss,
    input  logic spi_mosi,
    input  logic spi_miso,
    input  logic gpio_data,
    input  logic gpio_dir,
    output logic pin_out,
    output logic pin_oe
);
    owner_e owner;
    logic   spi_sig;
    logic   spi_drive;

    always_comb begin
        if (pwm_en)      owner = OWNER_PWM;
        else if (spi_en) owner = OWNER_SPI;
        else             owner = OWNER_GPIO;
    end

    always_comb begin
        unique case (ROLE)
            ROLE_SCK:  spi_sig = spi_sck;
            ROLE_SS:   spi_sig = spi_ss;
            ROLE_MOSI: spi_sig = spi_mosi;
            default:   spi_sig = spi_miso;
        endcase
        spi_drive = spi_master ? (ROLE != ROLE_MISO) : (ROLE == ROLE_MISO);
    end

    always_comb begin
        unique case (owner)
            OWNER_PWM: begin
                pin_out = pwm_val;
                pin_oe  = 1'b1;
            end
            OWNER_SPI: begin
                pin_out = spi_sig;
                pin_oe  = spi_drive;
            end
            default: begin
                pin_out = gpio_data;
                pin_oe  = gpio_dir;
            end
        endcase
    end

    assert_pwm_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |-> (pin_oe && (pin_out == pwm_val)));

    assert_spi_master_miso_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en && spi_en && spi_master && ROLE == ROLE_MISO) |-> !pin_oe);

    assert_gpio_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en && !spi_en) |-> ((pin_out == gpio_data) && (pin_oe == gpio_dir)));

endmodule

// File: rtl/pin_owner_mux.sv
module pin_owner_mux
    import pinmux_pkg::*;
#(
    parameter int          SPI_COUNT = 2,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] DATA_ADDR = 16'h0258,
    parameter logic [15:0] DIR_ADDR  = 16'h025A,
    localparam int         PORT_W    = 4 * SPI_COUNT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [PORT_W-1:0]    bus_wdata,
    output logic [PORT_W-1:0]    bus_rdata,
    input  logic [PORT_W-1:0]    pwm_en,
    input  logic [PORT_W-1:0]    pwm_val,
    input  logic [SPI_COUNT-1:0] spi_en,
    input  logic [SPI_COUNT-1:0] spi_master,
    input  logic [SPI_COUNT-1:0] spi_sck,
    input  logic [SPI_COUNT-1:0] spi_ss,
    input  logic [SPI_COUNT-1:0] spi_mosi,
    input  logic [SPI_COUNT-1:0] spi_miso,
    input  logic [PORT_W-1:0]    pin_in,
    output logic [PORT_W-1:0]    pin_out,
    output logic [PORT_W-1:0]    pin_oe
);
    logic [PORT_W-1:0] pin_level;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] dir_q;

    pin_sync #(.WIDTH(PORT_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_level)
    );

    port_regs #(
        .ADDR_W    (ADDR_W),
        .PORT_W    (PORT_W),
        .DATA_ADDR (DATA_ADDR),
        .DIR_ADDR  (DIR_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_level (pin_level),
        .bus_rdata (bus_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q)
    );

    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
        localparam int        GRP  = p / 4;
        localparam spi_role_e ROLE = role_of(p);

        pin_owner_cell #(.ROLE(ROLE)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .pwm_en     (pwm_en[p]),
            .pwm_val    (pwm_val[p]),
            .spi_en     (spi_en[GRP]),
            .spi_master (spi_master[GRP]),
            .spi_sck    (spi_sck[GRP]),
            .spi_ss     (spi_ss[GRP]),
            .spi_mosi   (spi_mosi[GRP]),
            .spi_miso   (spi_miso[GRP]),
            .gpio_data  (data_q[p]),
            .gpio_dir   (dir_q[p]),
            .pin_out    (pin_out[p]),
            .pin_oe     (pin_oe[p])
        );
    end

    assert_reset_inputs_R1: assert property (@(posedge clk)
        (!rst_n) |=> (dir_q == '0 && data_q == '0));

endmodule

// File: tb/pin_owner_mux_bench.sv
`timescale 1ns/1ps
module pin_owner_mux_bench;
    localparam logic [15:0] DATA_A = 16'h0258;
    localparam logic [15:0] DIR_A  = 16'h025A;
    localparam logic [15:0] NONE_A = 16'h0259;

    // {pwm_en, pwm_val, spi_en, spi_master, exp_out, exp_oe}; data=A5 dir=0F, all SPI signals high
    localparam logic [35:0] VEC [8] = '{
        {8'h00, 8'h00, 2'b00, 2'b00, 8'hA5, 8'h0F},
        {8'hFF, 8'h3C, 2'b11, 2'b11, 8'h3C, 8'hFF},
        {8'h00, 8'h00, 2'b01, 2'b01, 8'hAF, 8'h0E},
        {8'h00, 8'h00, 2'b01, 2'b00, 8'hAF, 8'h01},
        {8'h00, 8'h00, 2'b10, 2'b10, 8'hF5, 8'hEF},
        {8'h00, 8'h00, 2'b10, 2'b00, 8'hF5, 8'h1F},
        {8'h0F, 8'h00, 2'b11, 2'b11, 8'hF0, 8'hEF},
        {8'hF0, 8'h50, 2'b01, 2'b00, 8'h5F, 8'hF1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pwm_en = '0;
    logic [7:0]  pwm_val = '0;
    logic [1:0]  spi_en = '0;
    logic [1:0]  spi_master = '0;
    logic [1:0]  spi_sck = '0;
    logic [1:0]  spi_ss = '0;
    logic [1:0]  spi_mosi = '0;
    logic [1:0]  spi_miso = '0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pin_owner_mux u_pin_owner_mux (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_en(pwm_en), .pwm_val(pwm_val), .spi_en(spi_en), .spi_master(spi_master),
        .spi_sck(spi_sck), .spi_ss(spi_ss), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(DATA_A, rd); check("R1 data", rd, 8'h00);
        bus_read(DIR_A, rd);  check("R1 dir", rd, 8'h00);
        check("R1 oe", pin_oe, 8'h00);

        bus_write(DATA_A, 8'hA5);
        bus_write(DIR_A, 8'h0F);
        bus_read(DIR_A, rd);  check("R9 dir readback", rd, 8'h0F);
        bus_read(DATA_A, rd); check("R2 mixed read", rd, 8'h05);

        // R3 synchronizer depth
        @(negedge clk); pin_in = 8'h3C;
        bus_read(DATA_A, rd); check("R3 one edge", rd, 8'h05);
        bus_read(DATA_A, rd); check("R3 two edges", rd, 8'h35);
        @(negedge clk); pin_in = 8'h00;

        // table walk: R4 R5 R7 owners
        spi_sck = 2'b11; spi_ss = 2'b11; spi_mosi = 2'b11; spi_miso = 2'b11;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            {pwm_en, pwm_val, spi_en, spi_master} = VEC[k][35:16];
            #1;
            check($sformatf("R4/R5/R7 vec%0d out", k), pin_out, VEC[k][15:8]);
            check($sformatf("R4/R5/R7 vec%0d oe", k), pin_oe, VEC[k][7:0]);
        end

        // R6 role mapping, one signal at a time
        @(negedge clk);
        pwm_en = '0; spi_sck = 2'b01; spi_ss = '0; spi_mosi = '0; spi_miso = '0;
        spi_en = 2'b01; spi_master = 2'b01;
        #1 check("R6 spi0 sck pin2", pin_out, 8'hA4);
        @(negedge clk); spi_sck = '0; spi_ss = 2'b01;
        #1 check("R6 spi0 ss pin3", pin_out, 8'hA8);
        @(negedge clk); spi_ss = '0; spi_sck = 2'b10; spi_en = 2'b10; spi_master = 2'b10;
        #1 check("R6 spi1 sck pin7", pin_out, 8'h85);
        @(negedge clk); spi_sck = '0; spi_ss = 2'b10;
        #1 check("R6 spi1 ss pin6", pin_out, 8'h45);

        // R8 hidden write under PWM
        @(negedge clk); spi_en = '0; spi_ss = '0; pwm_en = 8'hFF; pwm_val = 8'h00;
        bus_write(DATA_A, 8'h3C);
        #1 check("R4 pwm holds pins", pin_out, 8'h00);
        @(negedge clk); pwm_en = '0;
        #1 check("R8 value after release", pin_out, 8'h3C);
        check("R7 oe follows dir", pin_oe, 8'h0F);

        // R9 stray address
        bus_write(NONE_A, 8'hFF);
        bus_read(DATA_A, rd); check("R9 data kept", rd, 8'h0C);
        bus_read(DIR_A, rd);  check("R9 dir kept", rd, 8'h0F);
        bus_read(NONE_A, rd); check("R9 stray read", rd, 8'h00);

        // R2 full output read
        bus_write(DIR_A, 8'hFF);
        bus_read(DATA_A, rd); check("R2 output read", rd, 8'h3C);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule